// File: doc/BRIEF.md
# Machine Trap CSR Unit

This block holds the machine-level trap registers of a 64-bit core that runs compressed (16-bit) instructions: the trap vector base, the exception program counter, the trap cause, the trap value and the interrupt-enable and previous-privilege fields of the machine status word. Software reaches these registers through a single read/write port. In one access, the port returns the old contents and accepts a new value, which is the read-old/write-new behaviour of an atomic CSR swap.

When the pipeline raises its trap-entry strobe with the faulting PC, cause and trap value, every trap register is updated on the same clock edge. In that same cycle the unit drives the PC to fetch from next, which it derives from the stored vector base and mode. Writes to the vector register are made legal before they are stored. The reserved mode bit is forced to zero, so a handler address that is only 2-byte aligned, such as 0x43a, is stored as 0x438. The unit raises a one-cycle flag so that the silent change can be seen.

Top module: `mtrap_csr_unit`

## Requirements
- R1: A write to the vector register (select code 0) stores the written value with bit 1 forced to 0 and every other bit kept. Bit 0 is the mode: 0 is direct, 1 is vectored. Writing 0x8000043a therefore stores 0x80000438.
- R2: `csr_rdata` combinationally shows the register picked by `csr_sel`, as held before the current clock edge, and a write becomes visible from the next cycle. The select codes are 0 vector, 1 exception PC, 2 cause, 3 trap value and 4 status. Codes 5 to 7 read as zero and ignore writes.
- R3: On trap entry the cause register becomes the interrupt flag in bit 63 plus the 6-bit code in bits 5:0, with all other bits zero, so a breakpoint with code 3 reads 3. Software writes keep only those same bits.
- R4: On trap entry the exception PC takes `trap_pc` with bit 0 cleared, and the trap value takes `trap_tval`. A software write to the exception PC also clears bit 0.
- R5: The status word reads as the constant 0x0000000a00000000 with three fields inserted: MIE at bit 3, MPIE at bit 7 and MPP at bits 12:11. On trap entry MPP becomes 11, MPIE takes the old MIE and MIE clears, so 0xa00000080 becomes 0xa00001800. A software write of MPP as 01 or 10 stores 00.
- R6: `redirect_valid` follows `trap_valid` in the same cycle. `redirect_pc` is the vector base with its low two bits cleared. When the mode is vectored and the trap is an interrupt, the PC is that base plus 4 times the code.
- R7: `illegal_write` is high for exactly the one cycle after an accepted vector write whose value had bit 1 set. It is low at all other times.
- R8: When a trap strobe and a software write fall in the same cycle, the trap updates take effect and the write is discarded, with no `illegal_write` pulse.
- R9: After reset the vector register reads 0x80000004, the exception PC, cause and trap value read 0, and the status word reads 0xa00000080 (MIE 0, MPIE 1, MPP 00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Software write strobe |
| csr_sel | input | 3 | Register select code |
| csr_wdata | input | 64 | Software write value |
| csr_rdata | output | 64 | Value of the selected register before this edge |
| trap_valid | input | 1 | Trap-entry strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | 6 | Trap cause code |
| trap_pc | input | 64 | PC of the trapping instruction |
| trap_tval | input | 64 | Trap value to record |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 64 | Handler address |
| illegal_write | output | 1 | Previous vector write was changed by legalization |

## Verification
Several properties are checked on every cycle. Accepted vector writes are stored legalized. Each trap updates cause, exception PC, trap value and status in one edge. Exception redirects land on the cleared base. The illegal-write flag pulses only after a write with bit 1 set. A vector write that collides with a trap leaves the register unchanged. The bench's scenarios cover the rest: the exact literal values after reset, the breakpoint sequence that starts from the misaligned 0x43a handler address, vectored interrupt offsets, and the legalization of odd exception-PC writes and unsupported MPP writes. It also compares every register against a reference model across a long run of random accesses and traps.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  typedef enum logic [2:0] {
    SEL_TVEC   = 3'd0,
    SEL_EPC    = 3'd1,
    SEL_CAUSE  = 3'd2,
    SEL_TVAL   = 3'd3,
    SEL_STATUS = 3'd4
  } csr_sel_e;

  localparam int MIE_BIT  = 3;
  localparam int MPIE_BIT = 7;
  localparam int MPP_LO   = 11;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;
  localparam logic [1:0] PRIV_LOWEST  = 2'b00;

  typedef struct packed {
    logic [1:0] mpp;
    logic       mpie;
    logic       mie;
  } status_t;

endpackage

// File: rtl/mtrap_tvec_reg.sv
module mtrap_tvec_reg #(
  parameter int          XLEN       = 64,
  parameter int          CODE_W     = 6,
  parameter logic [63:0] RESET_TVEC = 64'h0000_0000_8000_0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wdata,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  output logic [XLEN-1:0]   tvec_q,
  output logic [XLEN-1:0]   target_pc,
  output logic              illegal_pulse
);

  localparam int SHIFT = 2;

  // Clear the reserved mode bit; the base and the direct/vectored bit pass through.
  function automatic logic [XLEN-1:0] legalize(input logic [XLEN-1:0] w);
    logic [XLEN-1:0] r;
    r    = w;
    r[1] = 1'b0;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] vec_target(input logic [XLEN-1:0] tv,
                                                 input logic irq,
                                                 input logic [CODE_W-1:0] code);
    logic [XLEN-1:0] base;
    base = {tv[XLEN-1:SHIFT], {SHIFT{1'b0}}};
    if (tv[0] && irq) return base + (XLEN'(code) << SHIFT);
    return base;
  endfunction

  logic [XLEN-1:0] legal_w;
  logic            changed;

  assign legal_w = legalize(wdata);
  assign changed = (legal_w != wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tvec_q        <= RESET_TVEC[XLEN-1:0];
      illegal_pulse <= 1'b0;
    end else begin
      illegal_pulse <= wr_en && changed;
      if (wr_en) tvec_q <= legal_w;
    end
  end

  assign target_pc = vec_target(tvec_q, trap_irq, trap_code);

endmodule

// File: rtl/mtrap_status_reg.sv
module mtrap_status_reg
  import mtrap_pkg::*;
#(
  parameter int          XLEN         = 64,
  parameter logic [63:0] STATUS_FIXED = 64'h0000_000a_0000_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  input  logic            trap_take,
  output status_t         st_q,
  output logic [XLEN-1:0] rdata
);

  function automatic logic [1:0] legal_mpp(input logic [1:0] m);
    return (m == PRIV_MACHINE) ? PRIV_MACHINE : PRIV_LOWEST;
  endfunction

  function automatic logic [XLEN-1:0] compose(input status_t s);
    logic [XLEN-1:0] r;
    r                     = STATUS_FIXED[XLEN-1:0];
    r[MIE_BIT]            = s.mie;
    r[MPIE_BIT]           = s.mpie;
    r[MPP_LO+1:MPP_LO]    = s.mpp;
    return r;
  endfunction

  status_t st_next;

  always_comb begin
    st_next = st_q;
    if (trap_take) begin
      st_next.mpp  = PRIV_MACHINE;
      st_next.mpie = st_q.mie;
      st_next.mie  = 1'b0;
    end else if (wr_en) begin
      st_next.mpp  = legal_mpp(wdata[MPP_LO+1:MPP_LO]);
      st_next.mpie = wdata[MPIE_BIT];
      st_next.mie  = wdata[MIE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '{mpp: PRIV_LOWEST, mpie: 1'b1, mie: 1'b0};
    end else begin
      st_q <= st_next;
    end
  end

  assign rdata = compose(st_q);

endmodule

// File: rtl/mtrap_cause_regs.sv
module mtrap_cause_regs #(
  parameter int XLEN   = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_epc,
  input  logic              wr_cause,
  input  logic              wr_tval,
  input  logic [XLEN-1:0]   wdata,
  input  logic              trap_take,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_tval,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   tval_q
);

  localparam int GAP_W = XLEN - 1 - CODE_W;

  // Compressed code keeps half-word alignment, so only bit 0 is dropped.
  function automatic logic [XLEN-1:0] align_pc(input logic [XLEN-1:0] pc);
    return {pc[XLEN-1:1], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] pack_cause(input logic irq,
                                                 input logic [CODE_W-1:0] code);
    return {irq, {GAP_W{1'b0}}, code};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (trap_take) begin
      epc_q   <= align_pc(trap_pc);
      cause_q <= pack_cause(trap_irq, trap_code);
      tval_q  <= trap_tval;
    end else begin
      if (wr_epc)   epc_q   <= align_pc(wdata);
      if (wr_cause) cause_q <= pack_cause(wdata[XLEN-1], wdata[CODE_W-1:0]);
      if (wr_tval)  tval_q  <= wdata;
    end
  end

endmodule

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit
  import mtrap_pkg::*;
#(
  parameter int          XLEN         = 64,
  parameter int          CODE_W       = 6,
  parameter logic [63:0] RESET_TVEC   = 64'h0000_0000_8000_0004,
  parameter logic [63:0] STATUS_FIXED = 64'h0000_000a_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [2:0]        csr_sel,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              trap_valid,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_tval,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              illegal_write
);

  // Named internal events for the checker.
  logic            wr_accept;
  logic            wr_dropped;
  logic            wr_tvec, wr_epc, wr_cause, wr_tval, wr_status;
  logic [XLEN-1:0] tvec_q, epc_q, cause_q, tval_q, status_rd;
  status_t         st_q;
  csr_sel_e        sel;

  assign sel        = csr_sel_e'(csr_sel);
  assign wr_accept  = csr_we && !trap_valid;
  assign wr_dropped = csr_we && trap_valid;

  assign wr_tvec    = wr_accept && (sel == SEL_TVEC);
  assign wr_epc     = wr_accept && (sel == SEL_EPC);
  assign wr_cause   = wr_accept && (sel == SEL_CAUSE);
  assign wr_tval    = wr_accept && (sel == SEL_TVAL);
  assign wr_status  = wr_accept && (sel == SEL_STATUS);

  mtrap_tvec_reg #(
    .XLEN(XLEN), .CODE_W(CODE_W), .RESET_TVEC(RESET_TVEC)
  ) u_tvec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_tvec), .wdata(csr_wdata),
    .trap_irq(trap_irq), .trap_code(trap_code),
    .tvec_q(tvec_q), .target_pc(redirect_pc), .illegal_pulse(illegal_write)
  );

  mtrap_status_reg #(
    .XLEN(XLEN), .STATUS_FIXED(STATUS_FIXED)
  ) u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_status), .wdata(csr_wdata),
    .trap_take(trap_valid), .st_q(st_q), .rdata(status_rd)
  );

  mtrap_cause_regs #(
    .XLEN(XLEN), .CODE_W(CODE_W)
  ) u_cause (
    .clk(clk), .rst_n(rst_n),
    .wr_epc(wr_epc), .wr_cause(wr_cause), .wr_tval(wr_tval), .wdata(csr_wdata),
    .trap_take(trap_valid), .trap_irq(trap_irq), .trap_code(trap_code),
    .trap_pc(trap_pc), .trap_tval(trap_tval),
    .epc_q(epc_q), .cause_q(cause_q), .tval_q(tval_q)
  );

  always_comb begin
    unique case (sel)
      SEL_TVEC:   csr_rdata = tvec_q;
      SEL_EPC:    csr_rdata = epc_q;
      SEL_CAUSE:  csr_rdata = cause_q;
      SEL_TVAL:   csr_rdata = tval_q;
      SEL_STATUS: csr_rdata = status_rd;
      default:    csr_rdata = '0;
    endcase
  end

  assign redirect_valid = trap_valid;

endmodule

// File: rtl/mtrap_csr_unit_chk.sv
module mtrap_csr_unit_chk
  import mtrap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [2:0]        csr_sel,
  input logic [XLEN-1:0]   csr_wdata,
  input logic              wr_accept,
  input logic              trap_valid,
  input logic              trap_irq,
  input logic [CODE_W-1:0] trap_code,
  input logic [XLEN-1:0]   trap_pc,
  input logic [XLEN-1:0]   trap_tval,
  input logic [XLEN-1:0]   redirect_pc,
  input logic              illegal_write,
  input logic [XLEN-1:0]   tvec_q,
  input logic [XLEN-1:0]   epc_q,
  input logic [XLEN-1:0]   cause_q,
  input logic [XLEN-1:0]   tval_q,
  input status_t           st_q
);

  localparam int GAP_W = XLEN - 1 - CODE_W;

  a_r1_tvec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && csr_sel == SEL_TVEC) |=>
      tvec_q == {$past(csr_wdata[XLEN-1:2]), 1'b0, $past(csr_wdata[0])});

  a_r3_cause_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> cause_q == {$past(trap_irq), {GAP_W{1'b0}}, $past(trap_code)});

  a_r4_epc_tval_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (epc_q == {$past(trap_pc[XLEN-1:1]), 1'b0}) &&
                   (tval_q == $past(trap_tval)));

  a_r5_status_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (st_q.mpp == 2'b11) && !st_q.mie && (st_q.mpie == $past(st_q.mie)));

  a_r6_exception_base: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_irq) |-> redirect_pc == {tvec_q[XLEN-1:2], 2'b00});

  a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_write |-> $past(wr_accept && csr_sel == SEL_TVEC && csr_wdata[1]));

  a_r7_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && csr_sel == SEL_TVEC && csr_wdata[1]) |=> illegal_write);

  a_r8_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && csr_we && csr_sel == SEL_TVEC) |=> ($stable(tvec_q) && !illegal_write));

endmodule

bind mtrap_csr_unit mtrap_csr_unit_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
  .wr_accept(wr_accept), .trap_valid(trap_valid), .trap_irq(trap_irq),
  .trap_code(trap_code), .trap_pc(trap_pc), .trap_tval(trap_tval),
  .redirect_pc(redirect_pc), .illegal_write(illegal_write),
  .tvec_q(tvec_q), .epc_q(epc_q), .cause_q(cause_q), .tval_q(tval_q), .st_q(st_q)
);

// File: tb/mtrap_csr_unit_tb.sv
`timescale 1ns/1ps
module mtrap_csr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_sel = 3'd0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        trap_valid = 1'b0;
  logic        trap_irq = 1'b0;
  logic [5:0]  trap_code = '0;
  logic [63:0] trap_pc = '0;
  logic [63:0] trap_tval = '0;
  logic        redirect_valid;
  logic [63:0] redirect_pc;
  logic        illegal_write;

  always #2.5 clk = ~clk;

  mtrap_csr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trap_valid(trap_valid),
    .trap_irq(trap_irq), .trap_code(trap_code), .trap_pc(trap_pc),
    .trap_tval(trap_tval), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .illegal_write(illegal_write)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Behavioural reference state.
  longint unsigned m_tvec, m_epc, m_cause, m_tval;
  int              m_mie, m_mpie, m_mpp;
  bit              m_ill;
  logic [63:0]     last_rd;
  bit              last_ill;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned m_read(input int sel);
    case (sel)
      0: return m_tvec;
      1: return m_epc;
      2: return m_cause;
      3: return m_tval;
      4: return 64'h0000_000a_0000_0000 + m_mie * 8 + m_mpie * 128 + m_mpp * 2048;
      default: return 0;
    endcase
  endfunction

  function automatic string sel_tag(input int sel);
    case (sel)
      0: return "R1";
      1: return "R4";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    m_tvec = 64'h8000_0004; m_epc = 0; m_cause = 0; m_tval = 0;
    m_mie = 0; m_mpie = 1; m_mpp = 0; m_ill = 0;
  endtask

  task automatic step(input bit we, input int sel, input logic [63:0] wd,
                      input bit tv, input bit irq, input int code,
                      input logic [63:0] pc, input logic [63:0] tval);
    longint unsigned base, exp_pc;
    @(negedge clk);
    csr_we = we; csr_sel = 3'(sel); csr_wdata = wd;
    trap_valid = tv; trap_irq = irq; trap_code = 6'(code);
    trap_pc = pc; trap_tval = tval;
    #1;
    last_rd = csr_rdata; last_ill = illegal_write;
    chk({sel_tag(sel), " read-old"}, csr_rdata, m_read(sel));
    chk("R7 flag", {63'd0, illegal_write}, {63'd0, m_ill});
    chk("R6 valid", {63'd0, redirect_valid}, {63'd0, tv});
    if (tv) begin
      base   = m_tvec - (m_tvec % 4);
      exp_pc = ((m_tvec % 2 == 1) && irq) ? base + 4 * code : base;
      chk("R6 target", redirect_pc, exp_pc);
    end
    @(posedge clk);
    m_ill = 0;
    if (tv) begin
      m_epc   = pc - (pc % 2);
      m_cause = (irq ? 64'h8000_0000_0000_0000 : 0) + code;
      m_tval  = tval;
      m_mpp = 3; m_mpie = m_mie; m_mie = 0;
    end else if (we) begin
      case (sel)
        0: begin
          m_ill  = ((wd / 2) % 2 == 1);
          m_tvec = m_ill ? wd - 2 : wd;
        end
        1: m_epc = wd - (wd % 2);
        2: m_cause = (wd[63] ? 64'h8000_0000_0000_0000 : 0) + (wd % 64);
        3: m_tval = wd;
        4: begin
          m_mie  = wd[3];
          m_mpie = wd[7];
          m_mpp  = (wd[12:11] == 2'b11) ? 3 : 0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic rd(input int sel);
    step(0, sel, '0, 0, 0, 0, '0, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9 reset values
    rd(0); chk("R9 tvec", last_rd, 64'h8000_0004);
    rd(1); chk("R9 epc", last_rd, 64'h0);
    rd(2); chk("R9 cause", last_rd, 64'h0);
    rd(4); chk("R9 status", last_rd, 64'h0000_000a_0000_0080);

    // R1/R2/R7 misaligned handler address
    step(1, 0, 64'h8000_043a, 0, 0, 0, '0, '0);
    chk("R2 swap returns old", last_rd, 64'h8000_0004);
    rd(0); chk("R1 legalized", last_rd, 64'h8000_0438);
    chk("R7 pulse", {63'd0, last_ill}, 64'd1);
    rd(0); chk("R7 one cycle", {63'd0, last_ill}, 64'd0);

    // Breakpoint trap: R3 R4 R5 R6
    step(0, 0, '0, 1, 0, 3, 64'h8000_042c, 64'h8000_042c);
    chk("R6 breakpoint redirect", redirect_pc, 64'h8000_0438);
    rd(2); chk("R3 breakpoint cause", last_rd, 64'd3);
    rd(1); chk("R4 epc", last_rd, 64'h8000_042c);
    rd(3); chk("R4 tval", last_rd, 64'h8000_042c);
    rd(4); chk("R5 status after trap", last_rd, 64'h0000_000a_0000_1800);

    // Vectored mode, R6 / R7 no pulse
    step(1, 0, 64'h8000_1001, 0, 0, 0, '0, '0);
    rd(0); chk("R7 legal write no pulse", {63'd0, last_ill}, 64'd0);
    step(0, 0, '0, 1, 1, 7, 64'h100, 64'h0);
    chk("R6 vectored irq", redirect_pc, 64'h8000_101c);
    rd(2); chk("R3 irq cause", last_rd, 64'h8000_0000_0000_0007);
    step(0, 0, '0, 1, 0, 2, 64'h2003, 64'h55);
    chk("R6 vectored exception base", redirect_pc, 64'h8000_1000);
    rd(1); chk("R4 trap pc bit0", last_rd, 64'h2002);

    // R4 software write to epc, R3 cause write masking
    step(1, 1, 64'h1235, 0, 0, 0, '0, '0);
    rd(1); chk("R4 epc write", last_rd, 64'h1234);
    step(1, 2, 64'hffff_ffff_ffff_ffff, 0, 0, 0, '0, '0);
    rd(2); chk("R3 cause write", last_rd, 64'h8000_0000_0000_003f);

    // R5 status write with unsupported MPP, then trap
    step(1, 4, 64'h0000_0000_0000_0808, 0, 0, 0, '0, '0);
    rd(4); chk("R5 mpp legalized", last_rd, 64'h0000_000a_0000_0008);
    step(0, 0, '0, 1, 0, 3, 64'h40, 64'h40);
    rd(4); chk("R5 mpie from mie", last_rd, 64'h0000_000a_0000_1880);

    // R2 unmapped select
    step(1, 5, 64'h1234, 0, 0, 0, '0, '0);
    rd(5); chk("R2 unmapped", last_rd, 64'h0);

    // R8 trap and write collide
    step(1, 0, 64'h9000_0002, 1, 0, 3, 64'h80, 64'h80);
    rd(0); chk("R8 write discarded", last_rd, 64'h8000_1000 + 1);
    chk("R8 no pulse", {63'd0, last_ill}, 64'd0);

    // Random traffic compared against the model each cycle
    for (int i = 0; i < 400; i++) begin
      step($urandom % 2, $urandom % 6, {$urandom, $urandom},
           ($urandom % 5) == 0, $urandom % 2, $urandom % 64,
           {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule